// File: doc/BRIEF.md
# Auto-incrementing code/data upload port

This block lets a host fill and inspect two on-chip word memories, one holding program code and one holding data, through just two 32-bit registers on a simple register bus. The host first writes the address/control register to pick a memory, a starting word and an access mode. In write mode, every later write to the data register stores one word and steps the address forward by one word. In readback mode, the addressed word is captured when the address is written, and the next data-register read returns it.

Code memory is filled only in whole 64-word pages. Each page carries a secret attribute, taken from the secret flag at the moment the page's first word is stored. Code readback from a secret page returns zero. While a page is part-way written, a code-busy flag locks the address/control register, so the page cannot be interrupted. An external transfer-busy input blocks data-register writes whenever it is high.

The bus has no back-pressure. Every access completes in the cycle it is presented, and read data appears on `bus_rdata` one clock after `bus_rd`. At most one of `bus_wr` and `bus_rd` is high in any cycle.

Top module: `upload_port`

## Requirements
- R1: After reset, the address/control register reads 0, `code_busy` and `align_err` are 0, and a data-register read returns 0.
- R2: The address/control register reads back these fields:
  - bits 15:2: the current word address.
  - bit 20: the target memory (1 = code, 0 = data).
  - bit 21: the readback mode.
  - bit 24: the live `xfer_busy_i` input.
  - bit 28: the secret flag.
  - bit 29: code-busy.
  - bit 31: the alignment error.
  
  All other bits read 0.
- R3: In write mode, a data-register write stores the word at the current address and advances the address by one word.
- R4: An address/control write with bit 21 set captures the addressed word. The first data-register read afterwards returns that word. Any further data-register read returns 0 until the address/control register is written again.
- R5: A code write-mode address whose bits 7:2 are not zero is ignored and sets `align_err`. The next accepted address/control write clears `align_err`.
- R6: `code_busy` rises when word 0 of a code page is stored, and stays high through the store of word 63. It falls right after word 63.
- R7: Address/control writes while `code_busy` is high are ignored.
- R8: A code page takes the secret flag (bit 28) as its secret attribute when its word 0 is stored. Code readback from a secret page returns 0. Rewriting the page with the flag clear makes its contents readable again.
- R9: While `xfer_busy_i` is high, data-register writes neither store a word nor advance the address.
- R10: While readback mode is set, data-register writes neither store a word nor advance the address.
- R11: Code and data memories are separate. The same word address in each holds independent contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_busy_i | input | 1 | Busy indication from an external transfer engine |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 1 | Register select: 0 = address/control, 1 = data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| code_busy | output | 1 | A code page is part-way written |
| align_err | output | 1 | The last rejected code address was not page-aligned |

## Verification
A wrong word address shows up on the very next address/control read in bits 15:2. It also shows up as a wrong word returned by a later readback. A lost or stuck page counter shows up as `code_busy` rising or falling one word too early or too late, so the bench samples it at word 1, word 63 and word 64. A wrong secret bit stays hidden until that page is read back, so each page is read back after it is written, once with the flag set and once with it clear.

// File: rtl/upl_pkg.sv
package upl_pkg;
  localparam int IDX_W      = 14;
  localparam int PAGE_WORDS = 64;
  localparam int PAGE_LSB   = 6;
  localparam int F_ADDR_LO  = 2;
  localparam int F_TGT      = 20;
  localparam int F_RB       = 21;
  localparam int F_XB       = 24;
  localparam int F_SEC      = 28;
  localparam int F_CB       = 29;
  localparam int F_ERR      = 31;
endpackage

// File: rtl/upl_mem.sv
module upl_mem #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    rdata <= store[addr];
  end
endmodule

// File: rtl/upl_ctrl.sv
module upl_ctrl
  import upl_pkg::*;
#(
  parameter int CODE_WORDS = 256,
  localparam int PAGES     = CODE_WORDS / PAGE_WORDS,
  localparam int PGW       = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             ctrl_rd,
  input  logic             data_rd,
  input  logic             word_wr,
  input  logic             xfer_busy_i,
  input  logic [31:0]      wdata,
  input  logic [31:0]      code_dout,
  input  logic [31:0]      data_dout,
  output logic [IDX_W-1:0] cur_addr,
  output logic [IDX_W-1:0] req_addr,
  output logic             tgt_code,
  output logic             rb_mode,
  output logic             rb_req,
  output logic             code_busy,
  output logic             align_err,
  output logic [31:0]      rdata
);
  logic             sec_q, rb_pend, rb_arm;
  logic [31:0]      rb_data;
  logic [PAGES-1:0] secret_q;
  logic             accept, w_code, w_rb, bad;
  logic [PGW-1:0]   pg;
  logic [31:0]      rb_word, status;
  logic             unused_wbits;

  assign req_addr = wdata[F_ADDR_LO +: IDX_W];
  assign w_code   = wdata[F_TGT];
  assign w_rb     = wdata[F_RB];
  assign bad      = w_code && !w_rb && (req_addr[PAGE_LSB-1:0] != '0);
  assign accept   = ctrl_wr && !code_busy;
  assign rb_req   = accept && w_rb;
  assign pg       = cur_addr[PAGE_LSB +: PGW];
  assign unused_wbits = ^{wdata[31:29], wdata[27:22], wdata[19:16], wdata[1:0]};

  always_comb begin
    if (!tgt_code)         rb_word = data_dout;
    else if (secret_q[pg]) rb_word = '0;
    else                   rb_word = code_dout;
  end

  always_comb begin
    status                           = '0;
    status[F_ADDR_LO +: IDX_W]       = cur_addr;
    status[F_TGT]                    = tgt_code;
    status[F_RB]                     = rb_mode;
    status[F_XB]                     = xfer_busy_i;
    status[F_SEC]                    = sec_q;
    status[F_CB]                     = code_busy;
    status[F_ERR]                    = align_err;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      tgt_code  <= 1'b0;
      rb_mode   <= 1'b0;
      sec_q     <= 1'b0;
      code_busy <= 1'b0;
      align_err <= 1'b0;
      rb_pend   <= 1'b0;
      rb_arm    <= 1'b0;
      rb_data   <= '0;
      secret_q  <= '0;
    end else begin
      if (accept && bad) begin
        align_err <= 1'b1;
      end else if (accept) begin
        cur_addr  <= req_addr;
        tgt_code  <= w_code;
        rb_mode   <= w_rb;
        sec_q     <= wdata[F_SEC];
        align_err <= 1'b0;
        rb_pend   <= w_rb;
        rb_arm    <= 1'b0;
      end else if (rb_pend) begin
        rb_pend <= 1'b0;
        rb_data <= rb_word;
        rb_arm  <= !data_rd;
      end else if (data_rd && rb_arm) begin
        rb_arm <= 1'b0;
      end else if (word_wr) begin
        cur_addr <= cur_addr + 1'b1;
        if (tgt_code) begin
          if (cur_addr[PAGE_LSB-1:0] == '0) begin
            code_busy    <= 1'b1;
            secret_q[pg] <= sec_q;
          end
          if (cur_addr[PAGE_LSB-1:0] == PAGE_LSB'(PAGE_WORDS - 1))
            code_busy <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (ctrl_rd) begin
      rdata <= status;
    end else if (data_rd) begin
      if (rb_pend)     rdata <= rb_word;
      else if (rb_arm) rdata <= rb_data;
      else             rdata <= '0;
    end
  end
endmodule

// File: rtl/upload_port.sv
module upload_port
  import upl_pkg::*;
#(
  parameter int CODE_WORDS = 256,
  parameter int DATA_WORDS = 256,
  localparam int CIW       = $clog2(CODE_WORDS),
  localparam int DIW       = $clog2(DATA_WORDS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xfer_busy_i,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic        bus_sel,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        code_busy,
  output logic        align_err
);
  logic [IDX_W-1:0] cur_addr, req_addr, mem_addr;
  logic             tgt_code, rb_mode, rb_req, word_wr;
  logic [31:0]      code_dout, data_dout;
  logic             unused_addr;

  assign word_wr     = bus_wr && bus_sel && !xfer_busy_i && !rb_mode;
  assign mem_addr    = rb_req ? req_addr : cur_addr;
  assign unused_addr = ^mem_addr;

  upl_ctrl #(.CODE_WORDS(CODE_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(bus_wr && !bus_sel), .ctrl_rd(bus_rd && !bus_sel),
    .data_rd(bus_rd && bus_sel), .word_wr(word_wr),
    .xfer_busy_i(xfer_busy_i), .wdata(bus_wdata),
    .code_dout(code_dout), .data_dout(data_dout),
    .cur_addr(cur_addr), .req_addr(req_addr), .tgt_code(tgt_code),
    .rb_mode(rb_mode), .rb_req(rb_req), .code_busy(code_busy),
    .align_err(align_err), .rdata(bus_rdata)
  );

  upl_mem #(.DEPTH(CODE_WORDS), .WIDTH(32)) u_code_mem (
    .clk(clk), .we(word_wr && tgt_code), .addr(mem_addr[CIW-1:0]),
    .wdata(bus_wdata), .rdata(code_dout)
  );

  upl_mem #(.DEPTH(DATA_WORDS), .WIDTH(32)) u_data_mem (
    .clk(clk), .we(word_wr && !tgt_code), .addr(mem_addr[DIW-1:0]),
    .wdata(bus_wdata), .rdata(data_dout)
  );
endmodule

// File: rtl/upload_port_chk.sv
module upload_port_chk
  import upl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_sel,
  input logic             xfer_busy_i,
  input logic             code_busy,
  input logic             align_err,
  input logic             rb_mode,
  input logic [IDX_W-1:0] cur_addr
);
  a_r7_busy_locks_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_sel && code_busy) |=> $stable(cur_addr));

  a_r9_xfer_blocks_word: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel && xfer_busy_i) |=> $stable(cur_addr));

  a_r10_rb_blocks_word: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel && rb_mode) |=> $stable(cur_addr));

  a_r3_word_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel && !xfer_busy_i && !rb_mode) |=> cur_addr == $past(cur_addr) + 1'b1);

  a_r6_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_busy) |-> $past(bus_wr && bus_sel));

  a_r6_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(code_busy) |-> $past(bus_wr && bus_sel));

  a_r5_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(align_err) |-> $past(bus_wr && !bus_sel));
endmodule

bind upload_port upload_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
  .xfer_busy_i(xfer_busy_i), .code_busy(code_busy), .align_err(align_err),
  .rb_mode(rb_mode), .cur_addr(cur_addr)
);

// File: tb/upload_port_test.sv
module upload_port_test;
  localparam logic [31:0] TGT = 32'h1 << 20;
  localparam logic [31:0] RB  = 32'h1 << 21;
  localparam logic [31:0] XB  = 32'h1 << 24;
  localparam logic [31:0] SEC = 32'h1 << 28;
  localparam logic [31:0] CB  = 32'h1 << 29;
  localparam logic [31:0] ERR = 32'h1 << 31;

  logic        clk = 0, rst_n = 0, xfer_busy_i = 0;
  logic        bus_wr = 0, bus_rd = 0, bus_sel = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        code_busy, align_err;

  int checks = 0, fails = 0;
  logic done = 0;
  logic rd_seen = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  upload_port uut (
    .clk(clk), .rst_n(rst_n), .xfer_busy_i(xfer_busy_i),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .code_busy(code_busy), .align_err(align_err)
  );

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic sel, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_rd = 1; bus_sel = sel;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic pin(input string t, input logic a, input logic e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", t, a, e);
    end
  endtask

  task automatic fill_page(input logic [31:0] base, input logic [31:0] val0);
    for (int i = 0; i < 64; i++) wr(1, val0 + i);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    pin("R1 code_busy", code_busy, 0);
    pin("R1 align_err", align_err, 0);
    rd(0, 32'h0, "R1 ctrl reset");
    rd(1, 32'h0, "R1 data reset");

    // R3 streaming data writes, R2 address field
    wr(0, 32'h14);
    wr(1, 32'hA0A0_0001);
    wr(1, 32'hB0B0_0002);
    wr(1, 32'hC0C0_0003);
    rd(0, 32'h20, "R3 R2 address advanced");

    // R4 single-word readback
    wr(0, 32'h14 | RB);
    rd(1, 32'hA0A0_0001, "R4 first readback");
    rd(1, 32'h0, "R4 second read empty");
    wr(0, 32'h18 | RB);
    rd(1, 32'hB0B0_0002, "R4 readback next word");
    // R10 writes ignored in readback mode
    wr(1, 32'hDEAD_BEEF);
    rd(0, 32'h18 | RB, "R10 address held");
    wr(0, 32'h18 | RB);
    rd(1, 32'hB0B0_0002, "R10 word not overwritten");

    // R9 transfer busy blocks data writes
    wr(0, 32'h40);
    wr(1, 32'h1111_2222);
    wr(0, 32'h40);
    xfer_busy_i = 1;
    wr(1, 32'h3333_4444);
    rd(0, 32'h40 | XB, "R9 R2 address held, busy mirrored");
    xfer_busy_i = 0;
    wr(0, 32'h40 | RB);
    rd(1, 32'h1111_2222, "R9 word not overwritten");

    // R5 unaligned code write address
    wr(0, TGT | 32'h44);
    pin("R5 align_err set", align_err, 1);
    rd(0, 32'h40 | RB | ERR, "R5 state unchanged");
    wr(0, TGT | SEC | 32'h100);
    pin("R5 align_err cleared", align_err, 0);
    rd(0, TGT | SEC | 32'h100, "R2 code target secret");

    // R6 / R7 page write of code page 1, secret
    pin("R6 idle before page", code_busy, 0);
    wr(1, 32'h1000);
    pin("R6 busy after word 0", code_busy, 1);
    for (int i = 1; i < 10; i++) wr(1, 32'h1000 + i);
    wr(0, 32'h14);
    rd(0, TGT | SEC | CB | 32'h128, "R7 ctrl write ignored");
    for (int i = 10; i < 63; i++) wr(1, 32'h1000 + i);
    pin("R6 busy at word 62", code_busy, 1);
    wr(1, 32'h1000 + 63);
    pin("R6 idle after word 63", code_busy, 0);
    rd(0, TGT | SEC | 32'h200, "R6 address into next page");

    // R8 code page 2 non-secret
    wr(0, TGT | 32'h200);
    fill_page(32'h200, 32'h2000);
    wr(0, TGT | RB | 32'h104);
    rd(1, 32'h0, "R8 secret page reads zero");
    wr(0, TGT | RB | 32'h208);
    rd(1, 32'h2002, "R8 plain page readable");

    // R8 rewrite page 1 without secret
    wr(0, TGT | 32'h100);
    fill_page(32'h100, 32'h3000);
    wr(0, TGT | RB | 32'h10C);
    rd(1, 32'h3003, "R8 page cleared of secret");

    // R11 memories separate
    wr(0, TGT | 32'h0);
    fill_page(32'h0, 32'h4000);
    wr(0, 32'h14 | RB);
    rd(1, 32'hA0A0_0001, "R11 data memory untouched");
    wr(0, TGT | RB | 32'h14);
    rd(1, 32'h4005, "R11 code memory word");

    repeat (4) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule